// File: doc/BRIEF.md
# Terminal-side serial link port controller

This block sits on the terminal (router) side of a high-speed synchronous serial link and runs entirely in one system clock domain. The far side supplies a send-timing strobe, a receive-timing strobe with its receive data, and an availability level. All of them are sampled as plain levels, and their edges act as gapped enables. The block returns the send-timing strobe to the far side as terminal timing, delayed by one system clock. It launches user bits on the leading edge of that strobe and captures receive bits on the trailing edge of the receive strobe.

Traffic moves only while both availability handshakes are up. The first is the block's own terminal-available output, raised when the user asks for the link. The second is the far side's available input. Each handshake has a settle window of `SETTLE_CLKS` system clocks after it rises, and no data is taken or delivered during that window. When the user releases the link, the terminal-available output stays high until the last bit has had a full strobe period and one more strobe has passed.

The far side can also ask the terminal to loop its receive timing and data back onto the send pair. The block honours that request unless its own loopback mode request is nonzero, in which case its own request wins.

Top module: `term_link_port`

## Requirements
- R1: While reset is asserted, and for the synchroniser cycles after release, every output is low.
- R2: From idle, `term_avail` rises one clock after `term_ready` is sampled high.
- R3: Unless a peer loopback is being honoured, `term_tim_out` equals `snd_tim_in` as sampled one clock earlier, with no other gating.
- R4: `tx_take` is high only on a sampled rising edge of `snd_tim_in` while `term_ready` and `tx_valid` are high, no peer loopback is honoured, `term_avail` has been high for more than `SETTLE_CLKS` clock edges, and `peer_avail` has been high for more than `SETTLE_CLKS` consecutive edges.
- R5: On every sampled rising edge of `snd_tim_in` while `term_avail` is high, `snd_dat_out` takes `tx_bit` one clock later if a bit was taken, and 0 otherwise. Between rising edges it holds its value for any gap length. While the link is idle it is 0.
- R6: `rx_valid` pulses for one clock after each sampled falling edge of `rcv_tim_in` that occurs while the link is up (as for R4, without the send-side conditions), and `rx_bit` then carries `rcv_dat_in` from that edge.
- R7: Every clock edge that samples `peer_avail` low forces `rx_valid` and `rx_bit` to 0 on the next clock.
- R8: If `term_ready` is sampled low while the link is up, no further bits are taken, and `term_avail` falls one clock after the second later rising edge of `snd_tim_in`.
- R9: While `peer_lpbk_req` is high and `lpbk_mode_in` is 2'b00, `term_tim_out` and `snd_dat_out` follow `rcv_tim_in` and `rcv_dat_in` one clock later, `snd_tim_in` is ignored, and `tx_take` and `rx_valid` stay low.
- R10: While `lpbk_mode_in` is nonzero, `peer_lpbk_req` has no effect: terminal timing and send data follow the normal path.
- R11: `lpbk_mode_out` equals `lpbk_mode_in` one clock later. Bit 0 is loop line A and bit 1 is loop line B. 2'b11 is a loop at the far unit's terminal port, 2'b01 is a loop at its line side, and 2'b10 is a remote line loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| term_ready | input | 1 | User wants the link up (level) |
| tx_valid | input | 1 | A user send bit is available |
| tx_bit | input | 1 | User send bit |
| tx_take | output | 1 | User send bit consumed this cycle |
| rx_valid | output | 1 | Received bit valid (one-clock pulse) |
| rx_bit | output | 1 | Received bit |
| lpbk_mode_in | input | 2 | Own loopback mode request from the user |
| lpbk_mode_out | output | 2 | Loopback mode lines to the far side |
| snd_tim_in | input | 1 | Send-timing strobe from the far side |
| rcv_tim_in | input | 1 | Receive-timing strobe from the far side |
| rcv_dat_in | input | 1 | Receive data from the far side |
| peer_avail | input | 1 | Far side available |
| peer_lpbk_req | input | 1 | Far side asks for a terminal loopback |
| term_tim_out | output | 1 | Terminal timing to the far side |
| snd_dat_out | output | 1 | Send data to the far side |
| term_avail | output | 1 | Terminal available to the far side |

## Verification
A settle counter that runs short or long shows up directly at `tx_take` or `rx_valid`. Each is one strobe edge early or missing at the first edge after the window, so the error appears within `SETTLE_CLKS`+1 clocks of a handshake rising. A drain state machine that advances on the wrong edge moves the fall of `term_avail` by at least one strobe period. A wrong loopback select corrupts `term_tim_out` on the very next clock, because the strobes toggle almost every cycle. The bench keeps a cycle model of these rules and compares every output on every clock, so a diverging register is reported in the first cycle it differs.

// File: rtl/lp_pkg.sv
package lp_pkg;
  typedef enum logic [1:0] {
    LP_IDLE   = 2'd0,
    LP_UP     = 2'd1,
    LP_DRAIN1 = 2'd2,
    LP_DRAIN2 = 2'd3
  } lp_state_e;
endpackage

// File: rtl/lp_rst_sync.sv
module lp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/lp_strobe_edge.sv
module lp_strobe_edge #(
  parameter bit FALLING = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic evt
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  generate
    if (FALLING) begin : g_fall
      assign evt = ~lvl & lvl_q;
    end else begin : g_rise
      assign evt = lvl & ~lvl_q;
    end
  endgenerate
endmodule

// File: rtl/lp_settle_timer.sv
module lp_settle_timer #(
  parameter int unsigned SETTLE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int unsigned CW = (SETTLE < 1) ? 1 : $clog2(SETTLE + 1);
  localparam logic [CW-1:0] LIM = CW'(SETTLE);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)            cnt_d = '0;
    else if (cnt_q != LIM) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = run && (cnt_q == LIM);
endmodule

// File: rtl/lp_handshake_fsm.sv
module lp_handshake_fsm
  import lp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      term_ready,
  input  logic      snd_rise,
  output lp_state_e state
);
  lp_state_e state_d;

  always_comb begin
    state_d = state;
    unique case (state)
      LP_IDLE:   if (term_ready)  state_d = LP_UP;
      LP_UP:     if (!term_ready) state_d = LP_DRAIN1;
      LP_DRAIN1: if (snd_rise)    state_d = LP_DRAIN2;
      LP_DRAIN2: if (snd_rise)    state_d = LP_IDLE;
      default:                    state_d = LP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= LP_IDLE;
    else        state <= state_d;
  end
endmodule

// File: rtl/term_link_port.sv
module term_link_port
  import lp_pkg::*;
#(
  parameter int unsigned SETTLE_CLKS = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       term_ready,
  input  logic       tx_valid,
  input  logic       tx_bit,
  output logic       tx_take,
  output logic       rx_valid,
  output logic       rx_bit,
  input  logic [1:0] lpbk_mode_in,
  output logic [1:0] lpbk_mode_out,
  input  logic       snd_tim_in,
  input  logic       rcv_tim_in,
  input  logic       rcv_dat_in,
  input  logic       peer_avail,
  input  logic       peer_lpbk_req,
  output logic       term_tim_out,
  output logic       snd_dat_out,
  output logic       term_avail
);
  logic      rst_sync_n;
  logic      snd_rise, rcv_fall;
  logic      ta_done, ca_done, link_ok, peer_loop;
  lp_state_e state;

  logic       tim_q, tim_d;
  logic       sd_q, sd_d;
  logic       rxv_q, rxv_d;
  logic       rxb_q, rxb_d;
  logic [1:0] mode_q;

  lp_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  lp_strobe_edge #(.FALLING(1'b0)) u_snd_edge (
    .clk(clk), .rst_n(rst_sync_n), .lvl(snd_tim_in), .evt(snd_rise)
  );

  lp_strobe_edge #(.FALLING(1'b1)) u_rcv_edge (
    .clk(clk), .rst_n(rst_sync_n), .lvl(rcv_tim_in), .evt(rcv_fall)
  );

  lp_handshake_fsm u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .term_ready(term_ready),
    .snd_rise(snd_rise), .state(state)
  );

  lp_settle_timer #(.SETTLE(SETTLE_CLKS)) u_ta_settle (
    .clk(clk), .rst_n(rst_sync_n), .run(state == LP_UP), .done(ta_done)
  );

  lp_settle_timer #(.SETTLE(SETTLE_CLKS)) u_ca_settle (
    .clk(clk), .rst_n(rst_sync_n), .run(peer_avail), .done(ca_done)
  );

  // Own loopback request takes priority over the peer's request.
  assign peer_loop = peer_lpbk_req && (lpbk_mode_in == 2'b00);
  assign link_ok   = ta_done && ca_done;
  assign tx_take   = snd_rise && link_ok && term_ready && tx_valid && !peer_loop;

  always_comb begin
    tim_d = peer_loop ? rcv_tim_in : snd_tim_in;

    if (peer_loop)            sd_d = rcv_dat_in;
    else if (state == LP_IDLE) sd_d = 1'b0;
    else if (snd_rise)        sd_d = tx_take ? tx_bit : 1'b0;
    else                      sd_d = sd_q;

    rxv_d = rcv_fall && link_ok && !peer_loop;

    if (!peer_avail) rxb_d = 1'b0;
    else if (rxv_d)  rxb_d = rcv_dat_in;
    else             rxb_d = rxb_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      tim_q  <= 1'b0;
      sd_q   <= 1'b0;
      rxv_q  <= 1'b0;
      rxb_q  <= 1'b0;
      mode_q <= 2'b00;
    end else begin
      tim_q  <= tim_d;
      sd_q   <= sd_d;
      rxv_q  <= rxv_d;
      rxb_q  <= rxb_d;
      mode_q <= lpbk_mode_in;
    end
  end

  assign term_tim_out  = tim_q;
  assign snd_dat_out   = sd_q;
  assign rx_valid      = rxv_q;
  assign rx_bit        = rxb_q;
  assign lpbk_mode_out = mode_q;
  assign term_avail    = (state != LP_IDLE);
endmodule

// File: rtl/lp_port_checker.sv
module lp_port_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       term_ready,
  input logic       tx_valid,
  input logic       tx_bit,
  input logic       tx_take,
  input logic       rx_valid,
  input logic       rx_bit,
  input logic [1:0] lpbk_mode_in,
  input logic [1:0] lpbk_mode_out,
  input logic       snd_tim_in,
  input logic       rcv_tim_in,
  input logic       rcv_dat_in,
  input logic       peer_avail,
  input logic       peer_lpbk_req,
  input logic       term_tim_out,
  input logic       snd_dat_out,
  input logic       term_avail
);
  assert_avail_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(term_avail) |-> $past(term_ready));

  assert_tim_echo_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(peer_lpbk_req && lpbk_mode_in == 2'b00) |=> term_tim_out == $past(snd_tim_in));

  assert_take_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |-> (term_avail && peer_avail && term_ready && tx_valid));

  assert_take_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |-> $rose(snd_tim_in));

  assert_launch_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |=> snd_dat_out == $past(tx_bit));

  assert_rx_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ($past(rcv_tim_in, 2) && !$past(rcv_tim_in)));

  assert_rx_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !peer_avail |=> (!rx_valid && !rx_bit));

  assert_drain_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(term_avail) |-> $past(snd_tim_in));

  assert_peer_loop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (peer_lpbk_req && lpbk_mode_in == 2'b00) |=>
      (term_tim_out == $past(rcv_tim_in) && snd_dat_out == $past(rcv_dat_in)));

  assert_peer_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (peer_lpbk_req && lpbk_mode_in == 2'b00) |-> !tx_take);

  assert_own_prio_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (peer_lpbk_req && lpbk_mode_in != 2'b00) |=> term_tim_out == $past(snd_tim_in));

  assert_mode_pass_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> lpbk_mode_out == $past(lpbk_mode_in));
endmodule

bind term_link_port lp_port_checker u_chk (
  .clk(clk), .rst_n(rst_sync_n), .term_ready(term_ready), .tx_valid(tx_valid),
  .tx_bit(tx_bit), .tx_take(tx_take), .rx_valid(rx_valid), .rx_bit(rx_bit),
  .lpbk_mode_in(lpbk_mode_in), .lpbk_mode_out(lpbk_mode_out),
  .snd_tim_in(snd_tim_in), .rcv_tim_in(rcv_tim_in), .rcv_dat_in(rcv_dat_in),
  .peer_avail(peer_avail), .peer_lpbk_req(peer_lpbk_req),
  .term_tim_out(term_tim_out), .snd_dat_out(snd_dat_out), .term_avail(term_avail)
);

// File: tb/sim_term_link_port.sv
module sim_term_link_port;
  localparam int unsigned SETTLE = 2;
  localparam int unsigned CYC_LIMIT = 20000;

  logic clk, rst_n;
  logic term_ready, tx_valid, tx_bit, tx_take, rx_valid, rx_bit;
  logic [1:0] lpbk_mode_in, lpbk_mode_out;
  logic snd_tim_in, rcv_tim_in, rcv_dat_in, peer_avail, peer_lpbk_req;
  logic term_tim_out, snd_dat_out, term_avail;

  int n_chk, n_fail;
  bit done;

  // Behavioural model of the requirements
  int   m_state;          // 0 idle, 1 up, 2 drain1, 3 drain2
  int   m_tac, m_cac;
  logic m_st_q, m_rt_q, m_tt, m_sd, m_rxv, m_rxb;
  logic [1:0] m_mode;

  term_link_port #(.SETTLE_CLKS(SETTLE)) u0 (
    .clk(clk), .rst_n(rst_n), .term_ready(term_ready), .tx_valid(tx_valid),
    .tx_bit(tx_bit), .tx_take(tx_take), .rx_valid(rx_valid), .rx_bit(rx_bit),
    .lpbk_mode_in(lpbk_mode_in), .lpbk_mode_out(lpbk_mode_out),
    .snd_tim_in(snd_tim_in), .rcv_tim_in(rcv_tim_in), .rcv_dat_in(rcv_dat_in),
    .peer_avail(peer_avail), .peer_lpbk_req(peer_lpbk_req),
    .term_tim_out(term_tim_out), .snd_dat_out(snd_dat_out), .term_avail(term_avail)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0b expected %0b", tag, $time, act, exp);
    end
  endtask

  task automatic model_reset();
    m_state = 0; m_tac = 0; m_cac = 0;
    m_st_q = 0; m_rt_q = 0; m_tt = 0; m_sd = 0; m_rxv = 0; m_rxb = 0; m_mode = 2'b00;
  endtask

  // One cycle: compare registered outputs, drive inputs, compare tx_take, advance model
  task automatic cyc(input logic tr, input logic tv, input logic tb, input logic [1:0] md,
                     input logic st, input logic rt, input logic rd,
                     input logic ca, input logic lc);
    logic far, st_rise, rt_fall, ca_ok, ta_ok, take, rxv_n;
    @(negedge clk);
    chk("R2 R8 term_avail", {1'b0, term_avail}, {1'b0, m_state != 0});
    chk("R3 R9 R10 term_tim_out", {1'b0, term_tim_out}, {1'b0, m_tt});
    chk("R5 R9 snd_dat_out", {1'b0, snd_dat_out}, {1'b0, m_sd});
    chk("R6 R7 rx_valid", {1'b0, rx_valid}, {1'b0, m_rxv});
    chk("R6 R7 rx_bit", {1'b0, rx_bit}, {1'b0, m_rxb});
    chk("R11 lpbk_mode_out", lpbk_mode_out, m_mode);
    term_ready = tr; tx_valid = tv; tx_bit = tb; lpbk_mode_in = md;
    snd_tim_in = st; rcv_tim_in = rt; rcv_dat_in = rd; peer_avail = ca; peer_lpbk_req = lc;
    #1;
    far     = lc && (md == 2'b00);
    st_rise = st && !m_st_q;
    rt_fall = !rt && m_rt_q;
    ca_ok   = ca && (m_cac == SETTLE);
    ta_ok   = (m_state == 1) && (m_tac == SETTLE);
    take    = st_rise && ca_ok && ta_ok && tr && tv && !far;
    chk("R4 R9 tx_take", {1'b0, tx_take}, {1'b0, take});
    if (rst_n) begin
      rxv_n = rt_fall && ca_ok && ta_ok && !far;
      m_tt  = far ? rt : st;
      if (far)               m_sd = rd;
      else if (m_state == 0) m_sd = 1'b0;
      else if (st_rise)      m_sd = take ? tb : 1'b0;
      m_rxb = !ca ? 1'b0 : (rxv_n ? rd : m_rxb);
      m_rxv = rxv_n;
      m_cac = !ca ? 0 : ((m_cac < SETTLE) ? m_cac + 1 : m_cac);
      m_tac = (m_state != 1) ? 0 : ((m_tac < SETTLE) ? m_tac + 1 : m_tac);
      case (m_state)
        0: if (tr)      m_state = 1;
        1: if (!tr)     m_state = 2;
        2: if (st_rise) m_state = 3;
        default: if (st_rise) m_state = 0;
      endcase
      m_st_q = st; m_rt_q = rt; m_mode = md;
    end
  endtask

  initial begin : watchdog
    #(CYC_LIMIT * 10 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual running expected done");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic st, rt, ca, tr, lc;
    logic [1:0] md;
    n_chk = 0; n_fail = 0; done = 0;
    void'($urandom(32'd1993));
    model_reset();
    rst_n = 1'b0;
    term_ready = 0; tx_valid = 0; tx_bit = 0; lpbk_mode_in = 2'b00;
    snd_tim_in = 0; rcv_tim_in = 0; rcv_dat_in = 0; peer_avail = 0; peer_lpbk_req = 0;
    repeat (3) @(negedge clk);
    // R1: outputs low in reset
    chk("R1 reset outputs", {term_avail, term_tim_out}, 2'b00);
    chk("R1 reset data", {snd_dat_out, rx_valid}, 2'b00);
    chk("R1 reset rx/take", {rx_bit, tx_take}, 2'b00);
    chk("R1 reset mode", lpbk_mode_out, 2'b00);
    rst_n = 1'b1;
    repeat (4) cyc(0, 0, 0, 2'b00, 0, 0, 0, 0, 0);

    // Directed R2/R4: both handshakes rise together, strobes every cycle
    st = 0; rt = 1;
    for (int i = 0; i < 12; i++) begin
      st = ~st; rt = ~rt;
      cyc(1, 1, i[0], 2'b00, st, rt, ~i[1], 1, 0);
    end
    // Directed R5: long gap in the send strobe, data must hold
    for (int i = 0; i < 9; i++) cyc(1, 1, 0, 2'b00, st, rt, 0, 1, 0);
    // Directed R8: shutdown with strobes spaced three cycles apart
    for (int i = 0; i < 12; i++) begin
      if (i % 3 == 0) st = ~st;
      cyc(0, 1, 1, 2'b00, st, rt, 0, 1, 0);
    end
    // Directed R9 then R10: peer loop, then own request overriding it
    for (int i = 0; i < 8; i++) begin
      rt = ~rt; st = ~st;
      cyc(1, 1, 1, 2'b00, st, rt, i[0], 1, 1);
    end
    for (int i = 0; i < 8; i++) begin
      rt = ~rt; st = ~st;
      cyc(1, 1, 1, (i < 4) ? 2'b11 : 2'b10, st, rt, i[1], 1, 1);
    end
    // Directed R7: far side drops availability mid-traffic
    for (int i = 0; i < 6; i++) begin
      rt = ~rt; st = ~st;
      cyc(1, 1, 1, 2'b01, st, rt, 1, 0, 0);
    end

    // Constrained random phase: gapped strobes, rare handshake and loop changes
    tr = 1; ca = 1; lc = 0; md = 2'b00;
    for (int i = 0; i < 8000; i++) begin
      if ($urandom % 3 == 0) st = ~st;
      if ($urandom % 3 == 0) rt = ~rt;
      if ($urandom % 250 == 0) ca = ~ca;
      if ($urandom % 300 == 0) tr = ~tr;
      if ($urandom % 200 == 0) lc = ~lc;
      if ($urandom % 180 == 0) md = ($urandom % 2 == 0) ? 2'b00 : 2'($urandom);
      cyc(tr, ($urandom % 4) != 0, 1'($urandom), md, st, rt, 1'($urandom), ca, lc);
    end

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule